// File: doc/BRIEF.md
# Tightly-Coupled Memory Access Router

This block sits behind a slave port and steers each doubleword access to one of three local RAMs. These are an A memory and a B memory, and the B memory is built either as one bank or as two banks. A 4-bit target code chooses between A and B. The byte address is checked against the configured size of the chosen memory. For a split B memory, a strap sets which address bit picks the bank. That bit is either address bit 3, which interleaves the banks doubleword by doubleword, or the top address bit of the combined size, which places one bank above the other.

The router drives an enable and a doubleword index for each RAM, and holds the RAMs as simple behavioural arrays. One cycle after each request it answers with an OKAY or SLVERR response. A small response state machine sequences that answer. Its states are `ST_IDLE` (no response), `ST_RD_OK` (read data from the RAM that was used), `ST_WR_OK` (write accepted) and `ST_ERR` (slave error, zero data). On every clock edge the state machine takes one transition. It goes to `ST_IDLE` when no request is present, to `ST_ERR` on a rejected request, to `ST_WR_OK` on a legal write, and to `ST_RD_OK` on a legal read. It can move from any state to any state.

Top module: `tcm_route`

## Requirements
- R1: Target code 4'b0001 enables only the A RAM, with index = address[22:3], whatever the bank count and strap settings; address bits [2:0] are ignored.
- R2: Target code 4'b0010 with `b_dual` = 0 enables only bank 0 of B, with index = address[22:3]; the strap has no effect; bank 1 is never enabled while `b_dual` = 0.
- R3: With `b_dual` = 1 and `bank_strap` = 0, address bit 3 picks the B bank (0 → bank 0, 1 → bank 1) and the index is address[22:4].
- R4: With `b_dual` = 1 and `bank_strap` = 1, address bit T picks the B bank (0 → bank 0, 1 → bank 1), where T = 11 + size code, and the index is address[22:3] with the bit for T cleared.
- R5: A size code n in 0..11 means 4 KB × 2^n, so the top bit is 11 + n. Codes 12..15 mean 8 MB, so the top bit is 22. For a split B memory the code gives the combined size of both banks.
- R6: If any address bit above the top bit of the chosen memory is 1, the request enables no RAM and gets SLVERR.
- R7: Any target code other than 4'b0001 and 4'b0010 enables no RAM and gets SLVERR.
- R8: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. `rsp_err` is 1 for SLVERR and 0 for OKAY. No RAM enable is high while `req_valid` is low.
- R9: An OKAY read returns the data last written to the same RAM and index. Error responses and write responses return all-zero `rsp_rdata`.
- R10: After reset, `rsp_valid` and `rsp_err` are 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_csel | input | 4 | Target code (0001 = A, 0010 = B) |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 64 | Write data |
| a_size | input | 4 | A memory size code |
| b_size | input | 4 | B memory size code (combined when split) |
| b_dual | input | 1 | 1 = B built as two banks |
| bank_strap | input | 1 | 1 = top size bit picks bank, 0 = bit 3 |
| a_en | output | 1 | A RAM enable |
| b0_en | output | 1 | B bank 0 enable |
| b1_en | output | 1 | B bank 1 enable |
| a_idx | output | 20 | A RAM doubleword index (zero when idle) |
| b0_idx | output | 20 | B bank 0 index (zero when idle) |
| b1_idx | output | 20 | B bank 1 index (zero when idle) |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | 1 = SLVERR, 0 = OKAY |
| rsp_rdata | output | 64 | Read data |

## Verification
The hardest case to reach from the ports is the same bank entry reached through both bank-select schemes. That requires a write under one strap setting and a read under the other, on two different addresses that must map to the same bank and index. The bench writes bank 1 through bit-3 selection at address 0x8 and reads it back through top-bit selection at address 0x2000 with a 16 KB combined size. It also covers the edges of the size check at both extremes: 4 KB with bit 12 set, 4 MB with bit 22 set, and an oversized size code that must clamp to 8 MB.

// File: rtl/tcm_route_pkg.sv
package tcm_route_pkg;

    localparam int ADDR_W    = 23;
    localparam int WORD_LSB  = 3;
    localparam int IDX_W     = ADDR_W - WORD_LSB;
    localparam int SZ_W      = 4;
    localparam int BASE_BIT  = 11;
    localparam int MAX_CODE  = ADDR_W - 1 - BASE_BIT;
    localparam int BIT_W     = 5;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_A    = 2'd1,
        TGT_B0   = 2'd2,
        TGT_B1   = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_OK = 2'd1,
        ST_WR_OK = 2'd2,
        ST_ERR   = 2'd3
    } rsp_state_e;

    // Top address bit for a size code; oversized codes clamp to the largest size.
    function automatic logic [BIT_W-1:0] top_bit(input logic [SZ_W-1:0] code);
        logic [BIT_W-1:0] r;
        if (code > SZ_W'(MAX_CODE))
            r = BIT_W'(ADDR_W - 1);
        else
            r = BIT_W'(BASE_BIT) + BIT_W'(code);
        return r;
    endfunction

endpackage

// File: rtl/tcm_decode.sv
module tcm_decode
    import tcm_route_pkg::*;
(
    input  logic [3:0]        csel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   a_size,
    input  logic [SZ_W-1:0]   b_size,
    input  logic              b_dual,
    input  logic              bank_strap,
    output tgt_e              tgt,
    output logic              err,
    output logic [IDX_W-1:0]  idx
);

    logic [BIT_W-1:0]  msb;
    logic              is_a;
    logic              is_b;
    logic              over;
    logic [IDX_W-1:0]  dw;
    logic              unused_low_bits;

    assign unused_low_bits = ^addr[WORD_LSB-1:0];
    assign dw   = addr[ADDR_W-1:WORD_LSB];
    assign is_a = (csel == 4'b0001);
    assign is_b = (csel == 4'b0010);

    always_comb begin
        msb  = is_a ? top_bit(a_size) : top_bit(b_size);
        over = |(addr >> (msb + BIT_W'(1)));
    end

    always_comb begin
        tgt = TGT_NONE;
        err = 1'b1;
        idx = '0;
        if ((is_a || is_b) && !over) begin
            err = 1'b0;
            if (is_a) begin
                tgt = TGT_A;
                idx = dw;
            end else if (!b_dual) begin
                tgt = TGT_B0;
                idx = dw;
            end else if (!bank_strap) begin
                tgt = addr[WORD_LSB] ? TGT_B1 : TGT_B0;
                idx = dw >> 1;
            end else begin
                tgt = addr[msb] ? TGT_B1 : TGT_B0;
                idx = dw & ~(IDX_W'(1) << (msb - BIT_W'(WORD_LSB)));
            end
        end
    end

endmodule

// File: rtl/tcm_ram.sv
module tcm_ram
    import tcm_route_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     row;
    logic              unused_high_idx;

    assign row             = idx[AW-1:0];
    assign unused_high_idx = ^idx[IDX_W-1:AW];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we)
                mem[row] <= wdata;
            else
                rdata <= mem[row];
        end
    end

endmodule

// File: rtl/tcm_rsp_fsm.sv
module tcm_rsp_fsm
    import tcm_route_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              dec_err,
    input  tgt_e              dec_tgt,
    input  logic [DATA_W-1:0] a_rdata,
    input  logic [DATA_W-1:0] b0_rdata,
    input  logic [DATA_W-1:0] b1_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_state_e state_q, state_d;
    tgt_e       sel_q;

    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (dec_err)
            state_d = ST_ERR;
        else if (req_write)
            state_d = ST_WR_OK;
        else
            state_d = ST_RD_OK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= TGT_NONE;
        end else begin
            state_q <= state_d;
            sel_q   <= req_valid ? dec_tgt : TGT_NONE;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WR_OK: rsp_valid = 1'b1;
            ST_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            ST_RD_OK: begin
                rsp_valid = 1'b1;
                unique case (sel_q)
                    TGT_A:    rsp_rdata = a_rdata;
                    TGT_B0:   rsp_rdata = b0_rdata;
                    TGT_B1:   rsp_rdata = b1_rdata;
                    TGT_NONE: rsp_rdata = '0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/tcm_route.sv
module tcm_route
    import tcm_route_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MEM_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_csel,
    input  logic [22:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [3:0]        a_size,
    input  logic [3:0]        b_size,
    input  logic              b_dual,
    input  logic              bank_strap,
    output logic              a_en,
    output logic              b0_en,
    output logic              b1_en,
    output logic [19:0]       a_idx,
    output logic [19:0]       b0_idx,
    output logic [19:0]       b1_idx,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int NUM_RAM = 3;

    tgt_e              dec_tgt;
    logic              dec_err;
    logic [IDX_W-1:0]  dec_idx;
    logic [NUM_RAM-1:0] ram_en;
    logic [DATA_W-1:0] ram_rdata [NUM_RAM];
    logic [IDX_W-1:0]  ram_idx   [NUM_RAM];

    tcm_decode u_decode (
        .csel       (req_csel),
        .addr       (req_addr),
        .a_size     (a_size),
        .b_size     (b_size),
        .b_dual     (b_dual),
        .bank_strap (bank_strap),
        .tgt        (dec_tgt),
        .err        (dec_err),
        .idx        (dec_idx)
    );

    generate
        for (genvar g = 0; g < NUM_RAM; g++) begin : g_ram
            assign ram_en[g]  = req_valid && (dec_tgt == tgt_e'(g + 1));
            assign ram_idx[g] = ram_en[g] ? dec_idx : '0;

            tcm_ram #(
                .DATA_W (DATA_W),
                .DEPTH  (MEM_DEPTH)
            ) u_ram (
                .clk   (clk),
                .en    (ram_en[g]),
                .we    (req_write),
                .idx   (ram_idx[g]),
                .wdata (req_wdata),
                .rdata (ram_rdata[g])
            );
        end
    endgenerate

    assign a_en   = ram_en[0];
    assign b0_en  = ram_en[1];
    assign b1_en  = ram_en[2];
    assign a_idx  = ram_idx[0];
    assign b0_idx = ram_idx[1];
    assign b1_idx = ram_idx[2];

    tcm_rsp_fsm #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .dec_err   (dec_err),
        .dec_tgt   (dec_tgt),
        .a_rdata   (ram_rdata[0]),
        .b0_rdata  (ram_rdata[1]),
        .b1_rdata  (ram_rdata[2]),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/tcm_route_chk.sv
module tcm_route_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [3:0]        req_csel,
    input logic              b_dual,
    input logic              a_en,
    input logic              b0_en,
    input logic              b1_en,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);

    logic bad_code;
    assign bad_code = (req_csel != 4'b0001) && (req_csel != 4'b0010);

    // R1: at most one RAM is ever enabled
    a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_en, b0_en, b1_en}));

    // R2: bank 1 stays off for a single-bank B memory
    a_r2_no_bank1_single: assert property (@(posedge clk) disable iff (!rst_n)
        !b_dual |-> !b1_en);

    // R7: foreign target codes touch no RAM
    a_r7_bad_code_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_code) |-> !(a_en || b0_en || b1_en));

    // R7: foreign target codes are answered with SLVERR
    a_r7_bad_code_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_code) |=> (rsp_valid && rsp_err));

    // R8: one response for each request cycle
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: no response without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: no RAM enable while idle
    a_r8_idle_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(a_en || b0_en || b1_en));

    // R9: error responses carry zero data
    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R9: write responses carry zero data
    a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

bind tcm_route tcm_route_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_csel  (req_csel),
    .b_dual    (b_dual),
    .a_en      (a_en),
    .b0_en     (b0_en),
    .b1_en     (b1_en),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tcm_route_test.sv
module tcm_route_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;

    typedef struct packed {
        logic [3:0]  csel;
        logic [22:0] addr;
        logic [3:0]  asz;
        logic [3:0]  bsz;
        logic        dual;
        logic        strap;
        logic [2:0]  en;      // {a, b0, b1}
        logic [19:0] idx;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 23'h000018, 4'd0,  4'd0,  1'b0, 1'b0, 3'b100, 20'h00003, 1'b0, 4'd1},
        '{4'd1, 23'h00001F, 4'd0,  4'd0,  1'b1, 1'b1, 3'b100, 20'h00003, 1'b0, 4'd1},
        '{4'd1, 23'h002008, 4'd2,  4'd0,  1'b1, 1'b1, 3'b100, 20'h00401, 1'b0, 4'd1},
        '{4'd1, 23'h001000, 4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd6},
        '{4'd1, 23'h001000, 4'd1,  4'd0,  1'b0, 1'b0, 3'b100, 20'h00200, 1'b0, 4'd6},
        '{4'd2, 23'h003FF8, 4'd0,  4'd2,  1'b0, 1'b0, 3'b010, 20'h007FF, 1'b0, 4'd2},
        '{4'd2, 23'h003FF8, 4'd0,  4'd2,  1'b0, 1'b1, 3'b010, 20'h007FF, 1'b0, 4'd2},
        '{4'd2, 23'h000008, 4'd0,  4'd2,  1'b1, 1'b0, 3'b001, 20'h00000, 1'b0, 4'd3},
        '{4'd2, 23'h000030, 4'd0,  4'd2,  1'b1, 1'b0, 3'b010, 20'h00003, 1'b0, 4'd3},
        '{4'd2, 23'h003FF8, 4'd0,  4'd2,  1'b1, 1'b0, 3'b001, 20'h003FF, 1'b0, 4'd3},
        '{4'd2, 23'h002008, 4'd0,  4'd2,  1'b1, 1'b1, 3'b001, 20'h00001, 1'b0, 4'd4},
        '{4'd2, 23'h000018, 4'd0,  4'd2,  1'b1, 1'b1, 3'b010, 20'h00003, 1'b0, 4'd4},
        '{4'd2, 23'h004000, 4'd0,  4'd2,  1'b1, 1'b1, 3'b000, 20'h00000, 1'b1, 4'd6},
        '{4'd2, 23'h004000, 4'd0,  4'd2,  1'b1, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd6},
        '{4'd1, 23'h7FFFF8, 4'd15, 4'd0,  1'b0, 1'b0, 3'b100, 20'hFFFFF, 1'b0, 4'd5},
        '{4'd1, 23'h400000, 4'd10, 4'd0,  1'b0, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd6},
        '{4'd2, 23'h400008, 4'd0,  4'd14, 1'b1, 1'b1, 3'b001, 20'h00001, 1'b0, 4'd5},
        '{4'd4, 23'h000000, 4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd7},
        '{4'd0, 23'h000000, 4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd7},
        '{4'd3, 23'h000008, 4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 20'h00000, 1'b1, 4'd7},
        '{4'd15, 23'h000008, 4'd0, 4'd0,  1'b1, 1'b1, 3'b000, 20'h00000, 1'b1, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [3:0]    req_csel = '0;
    logic [22:0]   req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    a_size = '0;
    logic [3:0]    b_size = '0;
    logic          b_dual = 1'b0;
    logic          bank_strap = 1'b0;
    logic          a_en, b0_en, b1_en;
    logic [19:0]   a_idx, b0_idx, b1_idx;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcm_route uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_csel   (req_csel),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .a_size     (a_size),
        .b_size     (b_size),
        .b_dual     (b_dual),
        .bank_strap (bank_strap),
        .a_en       (a_en),
        .b0_en      (b0_en),
        .b1_en      (b1_en),
        .a_idx      (a_idx),
        .b0_idx     (b0_idx),
        .b1_idx     (b1_idx),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; caller checks afterwards.
    task automatic drive(input logic [3:0] cs, input logic [22:0] ad, input logic [3:0] asz,
                         input logic [3:0] bsz, input logic du, input logic st,
                         input logic wr, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_csel   = cs;
        req_addr   = ad;
        a_size     = asz;
        b_size     = bsz;
        b_dual     = du;
        bank_strap = st;
        req_wdata  = wd;
    endtask

    task automatic idle_after_rsp();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R10 reset rsp", {62'd0, rsp_valid, rsp_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 after reset release", {63'd0, rsp_valid}, 64'd0);
        check({a_en, b0_en, b1_en} == 3'b000, "R8 idle enables", {61'd0, a_en, b0_en, b1_en}, 64'd0);

        // Decode table: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [19:0] ea, e0, e1;
            v = VECS[i];
            drive(v.csel, v.addr, v.asz, v.bsz, v.dual, v.strap, 1'b0, '0);
            #(CLK_PERIOD/4);
            ea = v.en[2] ? v.idx : 20'd0;
            e0 = v.en[1] ? v.idx : 20'd0;
            e1 = v.en[0] ? v.idx : 20'd0;
            check({a_en, b0_en, b1_en} == v.en, $sformatf("R%0d vec %0d enables", v.req, i),
                  {61'd0, a_en, b0_en, b1_en}, {61'd0, v.en});
            check(a_idx == ea && b0_idx == e0 && b1_idx == e1, $sformatf("R%0d vec %0d index", v.req, i),
                  {4'd0, a_idx, b0_idx, b1_idx}, {4'd0, ea, e0, e1});
            @(negedge clk);
            check(rsp_valid && rsp_err == v.err, $sformatf("R%0d vec %0d response (R8)", v.req, i),
                  {62'd0, rsp_valid, rsp_err}, {62'd0, 1'b1, v.err});
            if (v.err)
                check(rsp_rdata == '0, $sformatf("R9 vec %0d err data", i), rsp_rdata, 64'd0);
            idle_after_rsp();
            @(negedge clk);
            check(!rsp_valid, "R8 no response when idle", {63'd0, rsp_valid}, 64'd0);
        end

        // R9: write then read back from A at index 5
        drive(4'd1, 23'h000028, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 64'hA5A5_0001_DEAD_BEEF);
        @(negedge clk);
        check(rsp_valid && !rsp_err && rsp_rdata == '0, "R9 write response", rsp_rdata, 64'd0);
        req_write = 1'b0;
        req_addr  = 23'h00002F;
        @(negedge clk);
        check(rsp_valid && !rsp_err, "R8 back-to-back response", {62'd0, rsp_valid, rsp_err}, 64'd2);
        check(rsp_rdata == 64'hA5A5_0001_DEAD_BEEF, "R9 A readback", rsp_rdata, 64'hA5A5_0001_DEAD_BEEF);
        idle_after_rsp();

        // R3 + R4: write bank 1 index 0 through bit-3 selection, read through top-bit selection
        drive(4'd2, 23'h000008, 4'd0, 4'd2, 1'b1, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0);
        #(CLK_PERIOD/4);
        check(b1_en && b1_idx == 20'd0, "R3 write to bank 1", {43'd0, b1_en, b1_idx}, {43'd0, 1'b1, 20'd0});
        @(negedge clk);
        idle_after_rsp();
        drive(4'd2, 23'h002000, 4'd0, 4'd2, 1'b1, 1'b1, 1'b0, '0);
        #(CLK_PERIOD/4);
        check(b1_en && b1_idx == 20'd0, "R4 read bank 1", {43'd0, b1_en, b1_idx}, {43'd0, 1'b1, 20'd0});
        @(negedge clk);
        check(rsp_rdata == 64'h1234_5678_9ABC_DEF0, "R9 cross-scheme readback", rsp_rdata, 64'h1234_5678_9ABC_DEF0);
        idle_after_rsp();

        // R6 + R9: out-of-range write must not land; readback keeps old A data
        drive(4'd1, 23'h001028, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        #(CLK_PERIOD/4);
        check({a_en, b0_en, b1_en} == 3'b000, "R6 rejected write enables", {61'd0, a_en, b0_en, b1_en}, 64'd0);
        @(negedge clk);
        check(rsp_err && rsp_rdata == '0, "R6 rejected write response", {63'd0, rsp_err}, 64'd1);
        idle_after_rsp();
        drive(4'd1, 23'h000028, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(rsp_rdata == 64'hA5A5_0001_DEAD_BEEF, "R6 A data untouched", rsp_rdata, 64'hA5A5_0001_DEAD_BEEF);
        idle_after_rsp();

        // R7 + R9: rejected read returns zero
        drive(4'd8, 23'h000028, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(rsp_err && rsp_rdata == '0, "R7 bad code read data", rsp_rdata, 64'd0);
        idle_after_rsp();
        @(negedge clk);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule